// File: doc/BRIEF.md
# Multi-Width Serial SRAM Command Front End

This block is the slave-side front end of a serial static memory. It watches chip select, a serial clock and four data lines, all sampled by a faster system clock through short synchronizer chains. It decodes an 8-bit instruction, collects a 16-bit start address and then moves data bytes between the serial lines and a byte-wide memory port. The transfer width can be one, two or four lines per serial clock, and instructions switch between these widths at run time. The block also holds the two-bit access mode that a separate address sequencer uses to choose between single-byte, in-page wrap and whole-array stepping.

The memory side is a set of strobes. A load strobe carries the start address. A write strobe carries each completed byte. A read-step strobe fires each time a byte has been taken from the read data input. The sequencer owns the current address and advances it on write or read-step according to the access mode.

Top module: `sqsram_front`

## Requirements
- R1: After reset, all output enables are low, the lane width is one line, and `accessMode` reads 2'b01 (sequential).
- R2: In one-line width, instruction 0x03 followed by a 16-bit address returns memory data MSB first on IO1. Each bit is updated after a falling serial clock edge and is valid at the next rising edge. During data output only IO1 is enabled (`ioOe` = 4'b0010).
- R3: In one-line width, instruction 0x02 followed by a 16-bit address takes data from IO0 MSB first. Each complete byte gives one `memWe` pulse with that byte on `memWrData`, and the address arrives on `memStartAddr` with a `memAddrLoad` pulse.
- R4: Instruction 0x3B selects two-line width. Bit pairs travel on {IO1,IO0}, with IO1 carrying the higher bit. A read inserts one dummy byte (four clocks, no lines driven) after the address, then drives data with `ioOe` = 4'b0011.
- R5: Instruction 0x38 selects four-line width. Nibbles travel on IO3..IO0, high nibble first. A read inserts a two-clock dummy byte, then drives data with `ioOe` = 4'b1111.
- R6: Instruction 0xFF, sent in whichever width is active (four clocks in two-line, two clocks in four-line), returns the width to one line.
- R7: Instruction 0x01 stores bits 7:6 of the following byte as the access mode shown on `accessMode`. Instruction 0x05 returns {mode, 6'b000000}.
- R8: Chip select rising before a byte is complete discards that byte. A partial data byte produces no write, and the next transaction starts fresh.
- R9: An unknown instruction makes the block drive nothing and write nothing until chip select rises, and the lane width is left unchanged.
- R10: While chip select is high, every output enable is low.
- R11: Continuing a read or write past the first byte moves further bytes. Each byte consumed or written gives one step strobe to the sequencer, so following bytes come from or go to the stepped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| ioIn | input | 4 | Input levels of data lines IO3..IO0 |
| ioOut | output | 4 | Output levels for data lines IO3..IO0 |
| ioOe | output | 4 | Per-line output enable |
| memAddrLoad | output | 1 | Pulse: start address valid on memStartAddr |
| memStartAddr | output | 16 | Start address gathered from the bus |
| memWe | output | 1 | Pulse: write memWrData at the current address and step |
| memWrData | output | 8 | Byte to write |
| memRdStep | output | 1 | Pulse: memRdData was taken, step the address |
| memRdData | input | 8 | Byte at the sequencer's current address |
| accessMode | output | 2 | Mode register bits 7:6 for the sequencer |

## Verification
A wrong bit count or wrong lane width shows up first as the wrong number of clocks before `memAddrLoad` or the first driven data bit. Every data byte after that is then rotated or misplaced, and the first read-back check catches it. A missing dummy byte in the two- and four-line modes moves the enables one byte early, which the per-byte enable capture reveals within that transaction. A write strobe after an aborted byte, or a width that fails to return to one line, corrupts memory or the next one-line read, so each such case is followed by a read-back in one-line width.

// File: rtl/sqsram_pkg.sv
package sqsram_pkg;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_DUAL  = 8'h3B;
  localparam logic [7:0] OP_QUAD  = 8'h38;
  localparam logic [7:0] OP_ONE   = 8'hFF;
  localparam logic [7:0] OP_MRD   = 8'h05;
  localparam logic [7:0] OP_MWR   = 8'h01;

  typedef enum logic [1:0] {
    LANE1 = 2'd0,
    LANE2 = 2'd1,
    LANE4 = 2'd2
  } laneT;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_DUMMY, ST_RDAT, ST_WDAT, ST_MRD, ST_MWR, ST_SKIP
  } stT;

  // strobes from control to datapath
  typedef struct packed {
    logic addrShift;
    logic addrDone;
    logic wrByte;
    logic ldMem;
    logic ldMode;
    logic shOut;
    logic setMode;
    logic setLane;
    laneT newLane;
  } ctlT;

  // status from datapath to control
  typedef struct packed {
    logic       riseEv;
    logic       fallEv;
    logic       byteDone;
    logic [7:0] rxByte;
    logic       outStart;
    laneT       lane;
  } statT;

  function automatic logic [3:0] laneStep(laneT l);
    case (l)
      LANE2:   return 4'd2;
      LANE4:   return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/sqsram_dp.sv
module sqsram_dp
  import sqsram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic [3:0]        ioIn,
  input  ctlT               ctl,
  output statT              st,
  output logic              csIdle,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic              memAddrLoad,
  output logic [ADDR_W-1:0] memStartAddr,
  output logic              memWe,
  output logic [7:0]        memWrData,
  output logic              memRdStep,
  input  logic [7:0]        memRdData,
  output logic [1:0]        accessMode
);

  localparam int ACC_W = ADDR_W - 8;

  logic [SYNC_N-1:0]      csPipe;
  logic [SYNC_N-1:0]      sckPipe;
  logic [SYNC_N-1:0][3:0] ioPipe;
  logic                   sckLast;
  logic                   csS, sckS;
  logic [3:0]             ioS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      sckPipe <= '0;
      ioPipe  <= '0;
      sckLast <= 1'b0;
    end else begin
      csPipe  <= {csPipe[SYNC_N-2:0], csN};
      sckPipe <= {sckPipe[SYNC_N-2:0], sck};
      ioPipe  <= {ioPipe[SYNC_N-2:0], ioIn};
      sckLast <= sckS;
    end
  end

  assign csS  = csPipe[SYNC_N-1];
  assign sckS = sckPipe[SYNC_N-1];
  assign ioS  = ioPipe[SYNC_N-1];
  assign csIdle = csS;

  logic riseEv, fallEv;
  assign riseEv = sckS & ~sckLast & ~csS;
  assign fallEv = ~sckS & sckLast & ~csS;

  laneT       laneR;
  logic [1:0] modeR;
  logic [3:0] stepW;
  assign stepW = laneStep(laneR);

  // input side
  logic [7:0] shIn, rxNext;
  logic [2:0] inCnt;
  logic [3:0] inSum;
  assign inSum = {1'b0, inCnt} + stepW;

  always_comb begin
    case (laneR)
      LANE2:   rxNext = {shIn[5:0], ioS[1:0]};
      LANE4:   rxNext = {shIn[3:0], ioS[3:0]};
      default: rxNext = {shIn[6:0], ioS[0]};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn  <= '0;
      inCnt <= '0;
    end else if (csS) begin
      inCnt <= '0;
    end else if (riseEv) begin
      shIn  <= rxNext;
      inCnt <= inSum[2:0];
    end
  end

  // output side
  logic [7:0] outShift;
  logic [2:0] outCnt;
  logic       outLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      outCnt   <= '0;
      outLive  <= 1'b0;
    end else if (csS) begin
      outCnt  <= '0;
      outLive <= 1'b0;
    end else if (ctl.ldMem || ctl.ldMode) begin
      outShift <= ctl.ldMem ? memRdData : {modeR, 6'b000000};
      outCnt   <= stepW[2:0];
      outLive  <= 1'b1;
    end else if (ctl.shOut) begin
      outShift <= outShift << stepW;
      outCnt   <= outCnt + stepW[2:0];
    end
  end

  always_comb begin
    case (laneR)
      LANE2:   begin ioOut = {2'b00, outShift[7:6]}; ioOe = {2'b00, {2{outLive}}}; end
      LANE4:   begin ioOut = outShift[7:4];          ioOe = {4{outLive}};          end
      default: begin ioOut = {2'b00, outShift[7], 1'b0}; ioOe = {2'b00, outLive, 1'b0}; end
    endcase
  end

  // address, memory strobes, registers
  logic [ACC_W-1:0] addrAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrAcc      <= '0;
      memStartAddr <= '0;
      memAddrLoad  <= 1'b0;
      memWe        <= 1'b0;
      memWrData    <= '0;
      memRdStep    <= 1'b0;
      modeR        <= 2'b01;
      laneR        <= LANE1;
    end else begin
      memAddrLoad <= ctl.addrDone;
      memWe       <= ctl.wrByte;
      memRdStep   <= ctl.ldMem;
      if (ctl.addrShift) addrAcc <= ACC_W'({addrAcc, rxNext});
      if (ctl.addrDone)  memStartAddr <= {addrAcc, rxNext};
      if (ctl.wrByte)    memWrData <= rxNext;
      if (ctl.setMode)   modeR <= rxNext[7:6];
      if (ctl.setLane)   laneR <= ctl.newLane;
    end
  end

  assign accessMode = modeR;

  assign st.riseEv   = riseEv;
  assign st.fallEv   = fallEv;
  assign st.byteDone = riseEv & inSum[3];
  assign st.rxByte   = rxNext;
  assign st.outStart = (outCnt == 3'd0);
  assign st.lane     = laneR;

  // R10: lines released once chip select is seen high
  a_r10_release_on_deselect: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (ioOe == 4'b0000));

  // R3: one write strobe per completed byte, never back to back
  a_r3_single_write_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R8: address load is a single pulse per transaction
  a_r8_single_addr_load: assert property (@(posedge clk) disable iff (!rstN)
    memAddrLoad |=> !memAddrLoad);

  // R4: only the lane patterns of the three widths ever appear
  a_r4_lane_enables: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'b0000) || (ioOe == 4'b0010) || (ioOe == 4'b0011) || (ioOe == 4'b1111));

endmodule

// File: rtl/sqsram_ctl.sv
module sqsram_ctl
  import sqsram_pkg::*;
#(
  parameter int ADDR_BYTES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIdle,
  input  statT st,
  output ctlT  ctl
);

  localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  stT             state, nxt;
  logic           isRead;
  logic [ACW-1:0] addrCnt;

  always_comb begin
    ctl = '0;
    nxt = state;
    if (st.byteDone) begin
      case (state)
        ST_CMD: begin
          case (st.rxByte)
            OP_READ, OP_WRITE: nxt = ST_ADDR;
            OP_MRD:            nxt = ST_MRD;
            OP_MWR:            nxt = ST_MWR;
            OP_DUAL: begin ctl.setLane = 1'b1; ctl.newLane = LANE2; nxt = ST_SKIP; end
            OP_QUAD: begin ctl.setLane = 1'b1; ctl.newLane = LANE4; nxt = ST_SKIP; end
            OP_ONE:  begin ctl.setLane = 1'b1; ctl.newLane = LANE1; nxt = ST_SKIP; end
            default: nxt = ST_SKIP;
          endcase
        end
        ST_ADDR: begin
          ctl.addrShift = 1'b1;
          if (addrCnt == ACW'(ADDR_BYTES - 1)) begin
            ctl.addrDone = 1'b1;
            if (!isRead)             nxt = ST_WDAT;
            else if (st.lane == LANE1) nxt = ST_RDAT;
            else                     nxt = ST_DUMMY;
          end
        end
        ST_DUMMY: nxt = ST_RDAT;
        ST_WDAT:  ctl.wrByte = 1'b1;
        ST_MWR: begin ctl.setMode = 1'b1; nxt = ST_SKIP; end
        default: ;
      endcase
    end
    if (st.fallEv && (state == ST_RDAT || state == ST_MRD)) begin
      if (st.outStart) begin
        if (state == ST_RDAT) ctl.ldMem = 1'b1;
        else                  ctl.ldMode = 1'b1;
      end else begin
        ctl.shOut = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CMD;
      isRead  <= 1'b0;
      addrCnt <= '0;
    end else if (csIdle) begin
      state   <= ST_CMD;
      addrCnt <= '0;
    end else begin
      state <= nxt;
      if (st.byteDone && state == ST_CMD) isRead <= (st.rxByte == OP_READ);
      if (ctl.addrShift) addrCnt <= addrCnt + 1'b1;
    end
  end

  // R4/R5: dummy byte only exists in the wide modes
  a_r4_dummy_wide_only: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DUMMY) |-> (st.lane != LANE1));

  // R9: once ignoring, stay ignoring until deselect
  a_r9_skip_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP && !csIdle) |=> (state == ST_SKIP));

endmodule

// File: rtl/sqsram_front.sv
module sqsram_front
  import sqsram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic              memAddrLoad,
  output logic [ADDR_W-1:0] memStartAddr,
  output logic              memWe,
  output logic [7:0]        memWrData,
  output logic              memRdStep,
  input  logic [7:0]        memRdData,
  output logic [1:0]        accessMode
);

  localparam int ADDR_BYTES = ADDR_W / 8;

  ctlT  ctl;
  statT st;
  logic csIdle;

  sqsram_dp #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) i_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .ioIn(ioIn),
    .ctl(ctl), .st(st), .csIdle(csIdle),
    .ioOut(ioOut), .ioOe(ioOe),
    .memAddrLoad(memAddrLoad), .memStartAddr(memStartAddr),
    .memWe(memWe), .memWrData(memWrData),
    .memRdStep(memRdStep), .memRdData(memRdData),
    .accessMode(accessMode)
  );

  sqsram_ctl #(.ADDR_BYTES(ADDR_BYTES)) i_ctl (
    .clk(clk), .rstN(rstN), .csIdle(csIdle), .st(st), .ctl(ctl)
  );

endmodule

// File: tb/test_sqsram_front.sv
module test_sqsram_front;

  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 8;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sck = 1'b0;
  logic [3:0]  ioIn = 4'h0;
  logic [3:0]  ioOut, ioOe;
  logic        memAddrLoad, memWe, memRdStep;
  logic [15:0] memStartAddr;
  logic [7:0]  memWrData, memRdData;
  logic [1:0]  accessMode;

  int checks = 0;
  int fails  = 0;
  int weCount;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqsram_front i_sqsram_front (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe),
    .memAddrLoad(memAddrLoad), .memStartAddr(memStartAddr),
    .memWe(memWe), .memWrData(memWrData),
    .memRdStep(memRdStep), .memRdData(memRdData),
    .accessMode(accessMode)
  );

  // address sequencer and small memory model
  logic [7:0]  mem [256];
  logic [15:0] cur;

  function automatic logic [15:0] nxtA(logic [15:0] a, logic [1:0] m);
    case (m)
      2'b00:   return a;
      2'b10:   return {a[15:5], a[4:0] + 5'd1};
      default: return a + 16'd1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      cur <= '0;
      weCount <= 0;
    end else begin
      if (memAddrLoad) cur <= memStartAddr;
      else if (memWe) begin
        mem[cur[7:0]] <= memWrData;
        cur <= nxtA(cur, accessMode);
      end else if (memRdStep) cur <= nxtA(cur, accessMode);
      if (memWe) weCount <= weCount + 1;
    end
  end
  assign memRdData = mem[cur[7:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] drv, output logic [3:0] got, output logic [3:0] oe);
    ioIn = drv;
    repeat (SCK_HALF) @(negedge clk);
    got = ioOut;
    oe  = ioOe;
    sck = 1'b1;
    repeat (SCK_HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xbyte(input int lanes, input logic [7:0] tx,
                       output logic [7:0] rx, output logic [3:0] oeOr);
    logic [7:0] t;
    t = tx; rx = '0; oeOr = '0;
    for (int k = 0; k < 8 / lanes; k++) begin
      logic [3:0] d, g, o;
      case (lanes)
        1:       d = {3'b000, t[7]};
        2:       d = {2'b00, t[7:6]};
        default: d = t[7:4];
      endcase
      tick(d, g, o);
      case (lanes)
        1:       rx = {rx[6:0], g[1]};
        2:       rx = {rx[5:0], g[1:0]};
        default: rx = {rx[3:0], g};
      endcase
      oeOr = oeOr | o;
      t = t << lanes;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    repeat (SCK_HALF) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (SCK_HALF) @(negedge clk);
    csN = 1'b1;
    repeat (4 * SCK_HALF) @(negedge clk);
  endtask

  task automatic wrSeq(input int lanes, input logic [15:0] a, input int n, input logic [23:0] bytes);
    logic [7:0] r; logic [3:0] o;
    csLow();
    xbyte(lanes, 8'h02, r, o);
    xbyte(lanes, a[15:8], r, o);
    xbyte(lanes, a[7:0], r, o);
    for (int i = 0; i < n; i++) xbyte(lanes, bytes[23 - 8*i -: 8], r, o);
    csHigh();
  endtask

  task automatic rdSeq(input int lanes, input logic [15:0] a, input int n,
                       output logic [23:0] got, output logic [3:0] oeData, output logic [3:0] oeDummy);
    logic [7:0] r; logic [3:0] o;
    got = '0; oeData = '0; oeDummy = '0;
    csLow();
    xbyte(lanes, 8'h03, r, o);
    xbyte(lanes, a[15:8], r, o);
    xbyte(lanes, a[7:0], r, o);
    if (lanes > 1) xbyte(lanes, 8'h00, r, oeDummy);
    for (int i = 0; i < n; i++) begin
      xbyte(lanes, 8'h00, r, o);
      got = {got[15:0], r};
      oeData = oeData | o;
    end
    csHigh();
  endtask

  task automatic sendCmd(input int lanes, input logic [7:0] op);
    logic [7:0] r; logic [3:0] o;
    csLow(); xbyte(lanes, op, r, o); csHigh();
  endtask

  task automatic modeWr(input logic [7:0] v);
    logic [7:0] r; logic [3:0] o;
    csLow(); xbyte(1, 8'h01, r, o); xbyte(1, v, r, o); csHigh();
  endtask

  task automatic modeRd(output logic [7:0] v);
    logic [7:0] r; logic [3:0] o;
    csLow(); xbyte(1, 8'h05, r, o); xbyte(1, 8'h00, v, o); csHigh();
  endtask

  localparam logic [23:0] VEC [6] = '{
    24'h0010_3C, 24'h0123_A7, 24'h4555_01,
    24'h8A77_FE, 24'hFFF0_6D, 24'h0099_00
  };

  initial begin
    logic [23:0] got;
    logic [3:0]  oeD, oeZ, o;
    logic [7:0]  v, r;
    int          w0;

    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe after reset", 32'(ioOe), 32'h0);
    chk("R1 mode after reset", 32'(accessMode), 32'h1);
    modeRd(v);
    chk("R7 mode read default", 32'(v), 32'h40);

    // R2 R3 table of single-line writes then reads
    foreach (VEC[i]) wrSeq(1, VEC[i][23:8], 1, {VEC[i][7:0], 16'h0});
    chk("R3 write strobes", 32'(weCount), 32'd6);
    foreach (VEC[i]) begin
      rdSeq(1, VEC[i][23:8], 1, got, oeD, oeZ);
      chk("R2 single read data", 32'(got[7:0]), 32'(VEC[i][7:0]));
      chk("R2 single read enables", 32'(oeD), 32'h2);
    end

    // R10 deselected after read
    chk("R10 oe idle", 32'(ioOe), 32'h0);

    // R11 sequential multi-byte across 0x00FF
    wrSeq(1, 16'h00FE, 3, 24'h11_22_33);
    rdSeq(1, 16'h00FE, 3, got, oeD, oeZ);
    chk("R11 sequential burst", 32'(got), 32'h112233);

    // R7 page mode and mode register
    modeWr(8'h80);
    chk("R7 accessMode page", 32'(accessMode), 32'h2);
    modeRd(v);
    chk("R7 mode read page", 32'(v), 32'h80);
    wrSeq(1, 16'h003F, 2, 24'hC1_C2_00);
    rdSeq(1, 16'h0020, 1, got, oeD, oeZ);
    chk("R11 page wrap write", 32'(got[7:0]), 32'hC2);
    modeWr(8'h7F);
    chk("R7 low bits ignored", 32'(accessMode), 32'h1);

    // R8 abort inside a data byte and inside the address
    w0 = weCount;
    csLow();
    xbyte(1, 8'h02, r, o); xbyte(1, 8'h00, r, o); xbyte(1, 8'h40, r, o);
    for (int k = 0; k < 4; k++) begin logic [3:0] g, oo; tick(4'h1, g, oo); end
    csHigh();
    csLow(); xbyte(1, 8'h02, r, o); xbyte(1, 8'h00, r, o); csHigh();
    chk("R8 no write on abort", 32'(weCount), 32'(w0));
    rdSeq(1, 16'h0040, 1, got, oeD, oeZ);
    chk("R8 memory unchanged", 32'(got[7:0]), 32'(8'h40 ^ 8'h5A));

    // R9 unknown opcode
    oeD = '0;
    csLow();
    xbyte(1, 8'hA5, r, o);
    xbyte(1, 8'h03, r, o); oeD |= o;
    xbyte(1, 8'h00, r, o); oeD |= o;
    xbyte(1, 8'h10, r, o); oeD |= o;
    xbyte(1, 8'h00, r, o); oeD |= o;
    csHigh();
    chk("R9 nothing driven", 32'(oeD), 32'h0);
    chk("R9 no write", 32'(weCount), 32'(w0));
    rdSeq(1, 16'h0010, 1, got, oeD, oeZ);
    chk("R9 width unchanged", 32'(got[7:0]), 32'h3C);

    // R4 dual
    sendCmd(1, 8'h3B);
    wrSeq(2, 16'h1230, 2, 24'h9B_E4_00);
    rdSeq(2, 16'h1230, 2, got, oeD, oeZ);
    chk("R4 dual data", 32'(got[15:0]), 32'h9BE4);
    chk("R4 dual enables", 32'(oeD), 32'h3);
    chk("R4 dual dummy silent", 32'(oeZ), 32'h0);

    // R6 leave dual
    sendCmd(2, 8'hFF);
    rdSeq(1, 16'h1231, 1, got, oeD, oeZ);
    chk("R6 back to single from dual", 32'(got[7:0]), 32'hE4);
    chk("R6 single enables", 32'(oeD), 32'h2);

    // R5 quad
    sendCmd(1, 8'h38);
    wrSeq(4, 16'h4561, 1, 24'h7D_00_00);
    rdSeq(4, 16'h4561, 1, got, oeD, oeZ);
    chk("R5 quad data", 32'(got[7:0]), 32'h7D);
    chk("R5 quad enables", 32'(oeD), 32'hF);
    chk("R5 quad dummy silent", 32'(oeZ), 32'h0);
    sendCmd(4, 8'hFF);
    rdSeq(1, 16'h4561, 1, got, oeD, oeZ);
    chk("R6 back to single from quad", 32'(got[7:0]), 32'h7D);
    chk("R10 oe idle end", 32'(ioOe), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule